// File: doc/BRIEF.md
# Delayed Autocorrelation Frame Detector

This block watches a stream of received complex baseband samples and flags where the signal becomes periodic with a period of sixteen samples, as it does during a repeated training preamble and across the cyclic prefix of each OFDM data symbol. For every accepted sample it forms the product of that sample with the complex conjugate of the sample taken sixteen accepted samples before. It keeps a running sum of those products over the newest thirty-two samples, and a running sum of the received power over the same thirty-two samples.

When the squared correlation magnitude exceeds 0.75 squared times the squared window power, the detection level is raised. The test is done with exact integer arithmetic and uses no divider. Each rise of that level produces a one-cycle start pulse. A downstream symbol aligner uses the pulse as its timing reference for dropping the cyclic prefix. The raw correlation sum is also exported.

Samples are signed Q1.15 pairs qualified by a valid strobe. Cycles without the strobe leave all state untouched.

Top module: `acorr_frame_detect`

## Requirements
- R1: After a synchronous reset, `det_level`, `start_pulse`, `corr_re` and `corr_im` are all zero, and the delay history and window sums start from zero.
- R2: After the valid sample with index n (counting from 0 since reset) is accepted, `corr_re` + j·`corr_im` equals the sum over k = n-31..n, k ≥ 0, of x[k]·conj(x[k-16]), where x[m] = 0 for m < 0. The outputs show this value on the clock edge that follows the accepting edge and hold it until the next accepted sample reaches the output.
- R3: Cycles with `in_valid` low do not change the outputs or any window state, whatever is on the data inputs. Their only effect is that `start_pulse` returns to zero.
- R4: Once the window is full, `det_level` is updated together with the correlation outputs. It is 1 exactly when 16·(Cre² + Cim²) > 9·P², where P is the sum of in_re² + in_im² over samples n-31..n. The comparison is strict.
- R5: `det_level` stays 0 for the first 47 valid samples after reset (n < 47), whatever the correlation.
- R6: `start_pulse` is 1 for exactly one clock, on the update at which `det_level` goes from 0 to 1, and is 0 at all other times.
- R7: An all-zero input never raises `det_level`, because 0 > 0 is false.
- R8: The window sums do not overflow at full scale. With every sample equal to (-32768, -32768), the steady values are `corr_re` = 2^36 and `corr_im` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_re/in_im for this cycle |
| in_re | input | 16 | Real part, signed Q1.15 |
| in_im | input | 16 | Imaginary part, signed Q1.15 |
| det_level | output | 1 | Normalized correlation above threshold |
| start_pulse | output | 1 | One-cycle pulse on each rise of det_level |
| corr_re | output | 38 | Real part of windowed lag-16 correlation |
| corr_im | output | 38 | Imaginary part of windowed lag-16 correlation |

## Verification
The assertions assume that reset is held for at least one clock before the first valid sample and that data matters only when `in_valid` is high. They also assume that the power sum can never go negative, which is true only if every term that enters the window later leaves it unchanged. The stimulus always starts from reset and drives random values on the data pins during idle cycles. It runs periodic, pseudo-random, all-zero and full-scale sample sequences, so the level crosses the threshold in both directions, including while the window is still filling.

// File: rtl/acorr_pkg.sv
package acorr_pkg;

    // Width of one component of a received sample (Q1.15).
    localparam int SAMPLE_W = 16;
    // Product of two components plus the add of two such products.
    localparam int PROD_W   = 2 * SAMPLE_W + 1;

    // Lanes of the sliding-sum bank.
    localparam int LANE_RE  = 0;
    localparam int LANE_IM  = 1;
    localparam int LANE_PWR = 2;
    localparam int NLANE    = 3;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] re;
        logic signed [SAMPLE_W-1:0] im;
    } cplx_t;

    // Sign-extend a sample component to product width.
    function automatic logic signed [PROD_W-1:0] widen(input logic signed [SAMPLE_W-1:0] v);
        return PROD_W'(v);
    endfunction

endpackage

// File: rtl/acorr_delay_line.sv
module acorr_delay_line #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage[0] <= '0;
        end else if (en) begin
            stage[0] <= din;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[g] <= '0;
            end else if (en) begin
                stage[g] <= stage[g-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/acorr_slide_sum.sv
module acorr_slide_sum #(
    parameter int IN_W  = 33,
    parameter int DEPTH = 32,
    parameter int OUT_W = 38
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  term,
    output logic signed [OUT_W-1:0] sum
);

    logic [IN_W-1:0]        old_bits;
    logic signed [IN_W-1:0] old_term;

    acorr_delay_line #(.DEPTH(DEPTH), .W(IN_W)) hist_i (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .din  (term),
        .dout (old_bits)
    );

    assign old_term = old_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else if (en) begin
            sum <= sum + OUT_W'(term) - OUT_W'(old_term);
        end
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sum));

endmodule

// File: rtl/acorr_thresh.sv
module acorr_thresh #(
    parameter int SUM_W     = 38,
    parameter int THR_NUM   = 9,
    parameter int THR_SHIFT = 4
) (
    input  logic signed [SUM_W-1:0] c_re,
    input  logic signed [SUM_W-1:0] c_im,
    input  logic signed [SUM_W-1:0] pwr,
    output logic                    hit
);

    localparam int CMP_W = 2 * SUM_W + THR_SHIFT + 2;
    localparam logic signed [CMP_W-1:0] NUM_W = CMP_W'(THR_NUM);

    logic signed [CMP_W-1:0] cr, ci, pw, mag2, lhs, rhs;

    always_comb begin
        cr   = CMP_W'(c_re);
        ci   = CMP_W'(c_im);
        pw   = CMP_W'(pwr);
        mag2 = cr * cr + ci * ci;
        lhs  = mag2 <<< THR_SHIFT;
        rhs  = pw * pw * NUM_W;
        hit  = lhs > rhs;
    end

endmodule

// File: rtl/acorr_frame_detect.sv
module acorr_frame_detect
    import acorr_pkg::*;
#(
    parameter int LAG       = 16,
    parameter int WIN       = 32,
    parameter int THR_NUM   = 9,
    parameter int THR_SHIFT = 4,
    localparam int SUM_W    = PROD_W + $clog2(WIN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [SAMPLE_W-1:0]     in_re,
    input  logic [SAMPLE_W-1:0]     in_im,
    output logic                    det_level,
    output logic                    start_pulse,
    output logic signed [SUM_W-1:0] corr_re,
    output logic signed [SUM_W-1:0] corr_im
);

    localparam int FILL  = LAG + WIN;
    localparam int CNT_W = $clog2(FILL + 1);

    cplx_t cur, dly;
    logic [2*SAMPLE_W-1:0] dly_bits;

    assign cur.re = in_re;
    assign cur.im = in_im;

    acorr_delay_line #(.DEPTH(LAG), .W(2*SAMPLE_W)) lag_i (
        .clk  (clk),
        .rst  (rst),
        .en   (in_valid),
        .din  (cur),
        .dout (dly_bits)
    );
    assign dly = dly_bits;

    // Per-sample terms: x * conj(d) and |x|^2
    logic signed [PROD_W-1:0] xr, xi, dr, di;
    logic signed [PROD_W-1:0] lane_term [NLANE];
    logic signed [SUM_W-1:0]  lane_sum  [NLANE];

    always_comb begin
        xr = widen(cur.re);
        xi = widen(cur.im);
        dr = widen(dly.re);
        di = widen(dly.im);
        lane_term[LANE_RE]  = xr * dr + xi * di;
        lane_term[LANE_IM]  = xi * dr - xr * di;
        lane_term[LANE_PWR] = xr * xr + xi * xi;
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        acorr_slide_sum #(.IN_W(PROD_W), .DEPTH(WIN), .OUT_W(SUM_W)) sum_i (
            .clk  (clk),
            .rst  (rst),
            .en   (in_valid),
            .term (lane_term[g]),
            .sum  (lane_sum[g])
        );
    end

    // Fill tracking and stage-1 qualifiers
    logic [CNT_W-1:0] fill_cnt, cnt_next;
    logic             s1_valid, s1_filled;

    assign cnt_next = (fill_cnt == CNT_W'(FILL)) ? fill_cnt : fill_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt  <= '0;
            s1_valid  <= 1'b0;
            s1_filled <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                fill_cnt  <= cnt_next;
                s1_filled <= (cnt_next == CNT_W'(FILL));
            end
        end
    end

    // Stage 2: threshold and edge
    logic hit;

    acorr_thresh #(.SUM_W(SUM_W), .THR_NUM(THR_NUM), .THR_SHIFT(THR_SHIFT)) thr_i (
        .c_re (lane_sum[LANE_RE]),
        .c_im (lane_sum[LANE_IM]),
        .pwr  (lane_sum[LANE_PWR]),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            det_level   <= 1'b0;
            start_pulse <= 1'b0;
            corr_re     <= '0;
            corr_im     <= '0;
        end else if (s1_valid) begin
            det_level   <= hit & s1_filled;
            start_pulse <= hit & s1_filled & ~det_level;
            corr_re     <= lane_sum[LANE_RE];
            corr_im     <= lane_sum[LANE_IM];
        end else begin
            start_pulse <= 1'b0;
        end
    end

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R6
    pulse_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (det_level && !$past(det_level)));

    // R5
    fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_filled) |=> !det_level);

    // R8
    pwr_sign_chk: assert property (@(posedge clk) disable iff (rst)
        !lane_sum[LANE_PWR][SUM_W-1]);

    // R5
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CNT_W'(FILL));

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(det_level) && $stable(corr_re) && $stable(corr_im));

endmodule

// File: tb/acorr_frame_detect_tb_top.sv
`timescale 1ns/1ps
module acorr_frame_detect_tb_top;
    import acorr_pkg::*;

    localparam int SUM_W = PROD_W + $clog2(32);
    localparam int HMAX  = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [15:0] in_re = '0;
    logic [15:0] in_im = '0;
    logic det_level, start_pulse;
    logic signed [SUM_W-1:0] corr_re, corr_im;

    always #2.5 clk = ~clk;

    acorr_frame_detect dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_re       (in_re),
        .in_im       (in_im),
        .det_level   (det_level),
        .start_pulse (start_pulse),
        .corr_re     (corr_re),
        .corr_im     (corr_im)
    );

    int checks = 0;
    int failures = 0;
    int hist_re [HMAX];
    int hist_im [HMAX];
    int n = 0;
    bit prev_lvl = 1'b0;
    int exp_pulses = 0;
    int got_pulses = 0;
    bit [31:0] seed = 32'h1234_5678;

    function automatic logic [15:0] rnd16();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed[15:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference: direct window sum and exact threshold test.
    task automatic model(input int idx, output longint er, output longint ei, output bit lvl);
        longint p;
        logic signed [127:0] m, q;
        er = 0; ei = 0; p = 0;
        for (int k = idx - 31; k <= idx; k++) begin
            if (k >= 0) begin
                longint xr, xi, dr, di;
                xr = hist_re[k]; xi = hist_im[k];
                dr = (k >= 16) ? longint'(hist_re[k-16]) : 64'sd0;
                di = (k >= 16) ? longint'(hist_im[k-16]) : 64'sd0;
                er += xr * dr + xi * di;
                ei += xi * dr - xr * di;
                p  += xr * xr + xi * xi;
            end
        end
        m = (128'(er) * 128'(er) + 128'(ei) * 128'(ei)) * 16;
        q = 128'(p) * 128'(p) * 9;
        lvl = (idx + 1 >= 48) && (m > q);
    endtask

    task automatic send(input int r, input int i, input string ctag, input string ltag);
        longint er, ei;
        bit lvl, ep;
        string lt;
        hist_re[n] = r;
        hist_im[n] = i;
        in_valid = 1'b1;
        in_re = 16'(r);
        in_im = 16'(i);
        @(negedge clk);
        in_valid = 1'b0;
        in_re = rnd16();
        in_im = rnd16();
        @(negedge clk);
        model(n, er, ei, lvl);
        chk(longint'(corr_re) == er, ctag, "corr_re", longint'(corr_re), er);
        chk(longint'(corr_im) == ei, ctag, "corr_im", longint'(corr_im), ei);
        lt = (n + 1 < 48) ? "R5" : ltag;
        chk(det_level == lvl, lt, "det_level", longint'(det_level), longint'(lvl));
        ep = lvl && !prev_lvl;
        chk(start_pulse == ep, "R6", "start_pulse", longint'(start_pulse), longint'(ep));
        if (ep) exp_pulses++;
        if (start_pulse) got_pulses++;
        prev_lvl = lvl;
        n++;
    endtask

    task automatic idle(input int cyc);
        longint sr, si;
        bit sl;
        sr = corr_re; si = corr_im; sl = det_level;
        repeat (cyc) begin
            in_valid = 1'b0;
            in_re = rnd16();
            in_im = rnd16();
            @(negedge clk);
            chk(longint'(corr_re) == sr && longint'(corr_im) == si && det_level == sl && !start_pulse,
                "R3", "idle hold corr_re", longint'(corr_re), sr);
        end
    endtask

    function automatic int pat_re(input int k);
        return (((k * 5 + 3) % 16) - 8) * 2000;
    endfunction

    function automatic int pat_im(input int k);
        return (((k * 11 + 1) % 16) - 8) * 1500;
    endfunction

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(det_level == 1'b0, "R1", "det_level", longint'(det_level), 0);
        chk(start_pulse == 1'b0, "R1", "start_pulse", longint'(start_pulse), 0);
        chk(corr_re == '0 && corr_im == '0, "R1", "corr", longint'(corr_re), 0);

        // Periodic from the first sample: correlation rises during fill (R5), then R4/R6
        for (int k = 0; k < 70; k++) send(pat_re(k), pat_im(k), "R2", "R4");
        idle(5);
        // Pseudo-random segment: level falls (R4)
        for (int k = 0; k < 80; k++) send(int'($signed(rnd16())), int'($signed(rnd16())), "R2", "R4");
        // All-zero segment: never detects once the window is flushed (R7)
        for (int k = 0; k < 40; k++) send(0, 0, "R2", (k >= 31) ? "R7" : "R4");
        idle(3);
        // Periodic again: a second rising edge (R6)
        for (int k = 0; k < 70; k++) send(pat_re(k), pat_im(k), "R2", "R4");
        // Full-scale constant: no overflow (R8)
        for (int k = 0; k < 50; k++) send(-32768, -32768, "R8", "R4");
        chk(longint'(corr_re) == 64'sd68719476736, "R8", "full-scale corr_re", longint'(corr_re), 64'sd68719476736);
        chk(longint'(corr_im) == 0, "R8", "full-scale corr_im", longint'(corr_im), 0);
        chk(exp_pulses >= 2 && got_pulses == exp_pulses, "R6", "pulse count", got_pulses, exp_pulses);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule